// File: doc/BRIEF.md
# Seconds Counter With Interval Interrupt

This block is the timekeeping core of a small serial-attached clock. A free-running 32.768 kHz enable (`tick_en`) feeds a prescaler. When the oscillator is enabled, the prescaler advances a 32-bit seconds count. The count is a plain binary number of seconds from a reference point that software chooses.

A link layer, which handles the bit-level bus timing, delivers whole bytes on `rx_valid`/`rx_data`. It takes outgoing bytes with `tx_ready` and signals a bus reset with a one-cycle `bus_rst` strobe. The first byte after a bus reset is a function command. One command reads the clock through a frozen snapshot; the other writes the control byte and a new count. A new count is held in a buffer and moves into the counter only at the next bus reset.

The control byte has an interrupt enable, a 3-bit interval select and a duplicated oscillator-enable bit. An active-low pulse on `int_n`, four ticks long, marks each interval boundary. The first pulse after enabling comes at once or up to one interval later, depending on the current count.

Top module: `sec_rtc_core`

## Requirements
- R1: While the oscillator is on, the prescaler advances on every `tick_en`, and the seconds count gains one every 2^PRE_BITS ticks. The count wraps from FFFFFFFFh to 0.
- R2: While the oscillator is off, the prescaler and the seconds count hold their values whatever `tick_en` does.
- R3: The control byte has these fields: bit 7 interrupt enable, bits 6:4 interval select, bits 3 and 2 both report the oscillator state, and bits 1:0 read 0. On a write, bit 3 alone sets the oscillator. After reset, the control byte and the count are 0, `int_n` is 1 and `tx_valid` is 0.
- R4: Command byte 66h copies the count into the snapshot buffer when the command is taken. It then offers the control byte, followed by count bits 7:0, 15:8, 23:16 and 31:24. Ticks that arrive during the read do not alter the bytes offered.
- R5: A read that goes past the fifth byte repeats the same five-byte sequence from the same snapshot until `bus_rst`. After `bus_rst`, `tx_valid` is 0.
- R6: Command byte 99h is followed by the control byte, which takes effect at once, and then four count bytes, least significant first, into the buffer. At the next `bus_rst` the buffer is loaded into the count and the prescaler is cleared. If fewer than four count bytes arrived, the count is left unchanged.
- R7: Interval select codes 0 to 7 choose periods of 1, 4, 32, 64, 2048, 4096, 65536 and 131072 s. Each pulse starts on the rising edge of the divider stage whose period equals the chosen interval. For code 0 this stage is prescaler bit PRE_BITS-1; for the other codes it is count bit log2(period)-1.
- R8: If the selected stage is already 1 when the interrupt is enabled, a pulse starts within two clock cycles.
- R9: A pulse holds `int_n` low for exactly PULSE_TICKS (default 4) `tick_en` strobes.
- R10: With the interrupt enable at 0, `int_n` stays high.
- R11: A first byte that is neither command is ignored, and so is every byte after it, until `bus_rst`. `tx_valid` is 1 only during a read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe at 32.768 kHz |
| bus_rst | input | 1 | One-cycle bus-reset strobe from the link layer |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Link layer takes the offered byte |
| tx_valid | output | 1 | A byte is offered for reading |
| tx_data | output | 8 | Offered byte |
| int_n | output | 1 | Active-low interrupt pulse |

## Verification
The read and write path is tried with five pairs of control byte and count. The set includes unequal oscillator bits in both orders, the low control bits set, and counts of all ones, all zeros and alternating patterns. These show that field precedence and byte order are right, and that the snapshot repeats. Counting is tried across a normal step and across the 32-bit wrap, with the oscillator on and off, and with ticks arriving in the middle of a read. The interrupt is tried with three interval codes, with the selected stage at 1 and at 0 when enabled, and with the enable cleared. This tells an immediate pulse from a delayed one, and checks the exact pulse width in ticks.

// File: rtl/sec_rtc_core.sv
module sec_rtc_core #(
  parameter int PRE_BITS    = 15,
  parameter int PULSE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       bus_rst,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       int_n
);
  localparam logic [7:0] CMD_RD = 8'h66;
  localparam logic [7:0] CMD_WR = 8'h99;
  localparam int PW = $clog2(PULSE_TICKS + 1);

  typedef enum logic [1:0] {S_CMD, S_RD, S_WR, S_SKIP} st_t;

  logic [PRE_BITS-1:0] pre;
  logic [31:0] sec, snap;
  logic        ie, osc, wfull, gate_q, sel_bit;
  logic [2:0]  isel, idx;
  logic [PW-1:0] pcnt;
  st_t         st;

  wire rd_take = tx_valid && tx_ready;
  wire gate    = ie && sel_bit;
  wire [7:0] ctrl_rd = {ie, isel, osc, osc, 2'b00};

  assign tx_valid = (st == S_RD);
  assign int_n    = (pcnt == '0);

  always_comb begin
    case (isel)
      3'd0:    sel_bit = pre[PRE_BITS-1];
      3'd1:    sel_bit = sec[1];
      3'd2:    sel_bit = sec[4];
      3'd3:    sel_bit = sec[5];
      3'd4:    sel_bit = sec[10];
      3'd5:    sel_bit = sec[11];
      3'd6:    sel_bit = sec[15];
      default: sel_bit = sec[16];
    endcase
  end

  always_comb begin
    case (idx)
      3'd1:    tx_data = snap[7:0];
      3'd2:    tx_data = snap[15:8];
      3'd3:    tx_data = snap[23:16];
      3'd4:    tx_data = snap[31:24];
      default: tx_data = ctrl_rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      sec <= '0;
    end else if (bus_rst && wfull) begin
      sec <= snap;
      pre <= '0;
    end else if (osc && tick_en) begin
      pre <= pre + 1'b1;
      if (&pre) sec <= sec + 32'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_CMD;
      idx   <= '0;
      wfull <= 1'b0;
      snap  <= '0;
      ie    <= 1'b0;
      isel  <= '0;
      osc   <= 1'b0;
    end else if (bus_rst) begin
      st    <= S_CMD;
      idx   <= '0;
      wfull <= 1'b0;
    end else begin
      case (st)
        S_CMD: if (rx_valid) begin
          idx <= '0;
          if (rx_data == CMD_RD) begin
            snap <= sec;
            st   <= S_RD;
          end else if (rx_data == CMD_WR) begin
            st <= S_WR;
          end else begin
            st <= S_SKIP;
          end
        end
        S_RD: if (rd_take) idx <= (idx == 3'd4) ? 3'd0 : idx + 3'd1;
        S_WR: if (rx_valid) begin
          idx <= idx + 3'd1;
          case (idx)
            3'd0: begin
              ie   <= rx_data[7];
              isel <= rx_data[6:4];
              osc  <= rx_data[3];
            end
            3'd1: snap[7:0]   <= rx_data;
            3'd2: snap[15:8]  <= rx_data;
            3'd3: snap[23:16] <= rx_data;
            default: begin
              snap[31:24] <= rx_data;
              wfull       <= 1'b1;
              st          <= S_SKIP;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      pcnt   <= '0;
    end else begin
      gate_q <= gate;
      if (gate && !gate_q)               pcnt <= PW'(PULSE_TICKS);
      else if (tick_en && pcnt != '0)    pcnt <= pcnt - PW'(1);
    end
  end

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rst) |-> (sec == $past(sec) || sec == $past(sec) + 32'd1)); // R1
  AST_OSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(osc) && !$past(bus_rst)) |-> $stable(sec)); // R2
  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && $past(st) == S_RD) |-> $stable(snap)); // R5
  AST_TX_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !tx_valid); // R5
  AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(ie)); // R10
  AST_PULSE_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> $past(tick_en)); // R9
endmodule

// File: tb/sec_rtc_core_tb_top.sv
module sec_rtc_core_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, bus_rst = 1'b0;
  logic rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_valid, int_n;
  logic [7:0] tx_data;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  sec_rtc_core #(.PRE_BITS(3), .PULSE_TICKS(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_rst(bus_rst),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .int_n(int_n));

  // {control written, control expected back, count}
  localparam logic [47:0] VEC [5] = '{
    {8'h00, 8'h00, 32'h1234_5678},
    {8'h04, 8'h00, 32'hA5C3_0F01},
    {8'h73, 8'h70, 32'hFFFF_FFFF},
    {8'h08, 8'h0C, 32'h0000_0000},
    {8'h7F, 8'h7C, 32'h8000_0001}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic pulse_rst();
    @(negedge clk) bus_rst = 1'b1;
    @(negedge clk) bus_rst = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin rx_valid = 1'b1; rx_data = b; end
    @(negedge clk) rx_valid = 1'b0;
  endtask

  task automatic take(output logic [7:0] b);
    @(negedge clk) begin tx_ready = 1'b1; b = tx_data; end
    @(negedge clk) tx_ready = 1'b0;
  endtask

  task automatic take_time(output logic [31:0] t);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      take(b);
      t[8*i +: 8] = b;
    end
  endtask

  task automatic read_all(output logic [7:0] c, output logic [31:0] t);
    send(8'h66);
    take(c);
    take_time(t);
    pulse_rst();
  endtask

  task automatic load(input logic [7:0] c, input logic [31:0] t);
    send(8'h99);
    send(c);
    for (int i = 0; i < 4; i++) send(t[8*i +: 8]);
    pulse_rst();
  endtask

  task automatic wr_ctrl(input logic [7:0] c);
    send(8'h99);
    send(c);
    pulse_rst();
  endtask

  task automatic quiet();
    wr_ctrl(8'h00);
    tick(4);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] c;
    logic [31:0] t;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    check(int_n == 1'b1, "R3 int_n reset", 32'(int_n), 1);
    check(tx_valid == 1'b0, "R3 tx_valid reset", 32'(tx_valid), 0);
    read_all(c, t);
    check(c == 8'h00, "R3 control reset", 32'(c), 0);
    check(t == 32'h0, "R3 count reset", t, 0);

    // table: write then double read (R3 R4 R5 R6)
    for (int v = 0; v < 5; v++) begin
      load(VEC[v][47:40], VEC[v][31:0]);
      send(8'h66);
      for (int p = 0; p < 2; p++) begin
        take(c);
        check(c == VEC[v][39:32], "R3 control readback", 32'(c), 32'(VEC[v][39:32]));
        take_time(t);
        check(t == VEC[v][31:0], p == 0 ? "R6 count load" : "R5 repeat pass", t, VEC[v][31:0]);
      end
      pulse_rst();
      check(tx_valid == 1'b0, "R5 tx_valid after bus reset", 32'(tx_valid), 0);
    end

    // R1 counting and wrap
    load(8'h08, 32'd100);
    tick(24);
    read_all(c, t);
    check(t == 32'd103, "R1 count step", t, 103);
    load(8'h08, 32'hFFFF_FFFF);
    tick(7);
    read_all(c, t);
    check(t == 32'hFFFF_FFFF, "R1 no step before prescaler wrap", t, 32'hFFFF_FFFF);
    tick(1);
    read_all(c, t);
    check(t == 32'h0, "R1 wrap", t, 0);

    // R2 oscillator off
    load(8'h00, 32'd777);
    tick(16);
    read_all(c, t);
    check(t == 32'd777, "R2 hold when off", t, 777);

    // R6 partial write leaves count
    load(8'h08, 32'd1000);
    send(8'h99); send(8'h00); send(8'h11); send(8'h22);
    pulse_rst();
    read_all(c, t);
    check(t == 32'd1000, "R6 partial write ignored", t, 1000);

    // R4 snapshot frozen during read
    load(8'h08, 32'd500);
    send(8'h66);
    take(c);
    tick(8);
    take_time(t);
    check(t == 32'd500, "R4 snapshot frozen", t, 500);
    take(c);
    take_time(t);
    check(t == 32'd500, "R5 second pass same snapshot", t, 500);
    pulse_rst();
    read_all(c, t);
    check(t == 32'd501, "R4 fresh snapshot", t, 501);

    // R11 unknown command
    send(8'h3C);
    send(8'h66);
    @(negedge clk);
    check(tx_valid == 1'b0, "R11 unknown command ignored", 32'(tx_valid), 0);
    pulse_rst();
    read_all(c, t);
    check(t == 32'd501, "R11 count untouched", t, 501);

    // R8 immediate pulse (code 1, count bit 1 already set)
    quiet();
    load(8'h08, 32'd2);
    send(8'h99);
    send(8'h98);
    repeat (2) @(negedge clk);
    check(int_n == 1'b0, "R8 immediate pulse", 32'(int_n), 0);
    pulse_rst();
    tick(3);
    check(int_n == 1'b0, "R9 low after 3 ticks", 32'(int_n), 0);
    tick(1);
    check(int_n == 1'b1, "R9 high after 4 ticks", 32'(int_n), 1);

    // R7 delayed pulse, code 1
    quiet();
    load(8'h08, 32'd0);
    wr_ctrl(8'h98);
    tick(8);
    check(int_n == 1'b1, "R7 code1 no pulse at 1 s", 32'(int_n), 1);
    tick(8);
    check(int_n == 1'b0, "R7 code1 pulse at 2 s", 32'(int_n), 0);

    // R7 code 0: prescaler top bit
    quiet();
    load(8'h08, 32'd0);
    wr_ctrl(8'h88);
    tick(3);
    check(int_n == 1'b1, "R7 code0 none after 3 ticks", 32'(int_n), 1);
    tick(1);
    check(int_n == 1'b0, "R7 code0 pulse at half second", 32'(int_n), 0);

    // R7 code 7: count bit 16
    quiet();
    load(8'h08, 32'h0000_FFFF);
    wr_ctrl(8'hF8);
    tick(7);
    check(int_n == 1'b1, "R7 code7 none before boundary", 32'(int_n), 1);
    tick(1);
    check(int_n == 1'b0, "R7 code7 pulse at 0x10000", 32'(int_n), 0);

    // R10 interrupt disabled
    quiet();
    load(8'h08, 32'd0);
    wr_ctrl(8'h18);
    ok = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tick(1);
      if (int_n !== 1'b1) ok = 1'b0;
    end
    check(ok, "R10 no pulse when disabled", 32'(ok), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule